// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination and Pending Aggregator

This block is the landing point for posted message-signalled interrupt writes. Each inbound write carries an address and a data word. The address selects one of 16 termination groups and, within that group, one of 8 index registers. The data value selects one of the 16 bits inside that register. The block sets that bit as a pending flag, so it covers 2048 distinct vectors. Each group has one level interrupt line. The line stays high while any index register of that group has a pending bit.

Software services a group through a small read port. A read of a group's summary register returns one bit per index register that holds pending work. A read of an index register returns its 16 pending bits and clears them in the same cycle. A termination write that arrives in that cycle is not lost.

The inbound write port is a plain strobe with no back-pressure. Every cycle with `wr_valid` high is taken. The read port returns its data one cycle after `rd_en`.

Top module: `msi_term_agg`

## Requirements
- R1: A write with data d in 0..15 to offset (n << 19) + (x << 16) sets bit d of index register x in group n. A read at that same offset then returns that bit set.
- R2: The summary register of group n sits at offset 0x800000 + (n << 16). Bit x of its read value is the OR of index register x of that group. Read bits 15:8 are zero.
- R3: `irq[n]` is high exactly when any summary bit of group n is set. It rises in the cycle after the clock edge that takes the setting write, and groups do not disturb each other.
- R4: A read of an index register presents its bits on `rd_data` in the cycle after `rd_en` and clears them. Once every index register of a group is drained, its summary reads zero and its `irq` falls.
- R5: A write and a clearing read may hit the same index register in the same cycle. The read then returns the content from before the write, and the written bit stays pending.
- R6: A write is dropped and no state changes if its data is above 15, if address bit 23 is set, or if address bits 15:0 are not zero.
- R7: Reset clears every pending bit and holds all 16 `irq` lines low.
- R8: Vector v is reached by a write with group v mod 16, index v / 256 and data (v / 16) mod 16.
- R9: Reading a summary register changes nothing. A read of an offset that is neither an index nor a summary register returns 0 and changes nothing. `rd_data` is 0 in any cycle that follows a cycle without `rd_en`.
- R10: Pending bits are sticky and coalesce. Repeated writes to one vector leave one bit set, and writes to several bits of one register accumulate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Termination write strobe, taken every cycle it is high |
| wr_addr | input | 24 | Termination write offset |
| wr_data | input | 32 | Termination write data (bit number) |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 24 | Register read offset |
| rd_data | output | 16 | Read result, valid the cycle after rd_en |
| irq | output | 16 | One level interrupt line per group |

## Verification
The bound checker watches several rules on every cycle. Reset keeps all lines low. A valid termination write raises its group's line on the next cycle. No line rises without a write in the cycle before. A dropped write leaves every line unchanged. `rd_data` is zero after an idle cycle. The bench scenarios cover the rest: the vector-to-address mapping, the summary contents, bits clearing on read, and the collision between a clearing read and a write to the same register. All of these need knowledge of earlier writes, so only the scenarios can show them.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  typedef enum logic [1:0] {
    KIND_NONE    = 2'd0,
    KIND_INDEX   = 2'd1,
    KIND_SUMMARY = 2'd2
  } reg_kind_e;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_term_pkg::*;
#(
  parameter int GRP_W     = 4,
  parameter int IDX_W     = 3,
  parameter int REG_SHIFT = 16,
  localparam int ADDR_W   = REG_SHIFT + IDX_W + GRP_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [GRP_W-1:0]  grp,
  output logic [IDX_W-1:0]  idx
);
  logic low_clear;
  assign low_clear = (addr[REG_SHIFT-1:0] == '0);

  always_comb begin
    kind = KIND_NONE;
    grp  = '0;
    idx  = '0;
    if (!addr[ADDR_W-1]) begin
      // index space: group above index above the register stride
      grp = addr[ADDR_W-2 -: GRP_W];
      idx = addr[REG_SHIFT +: IDX_W];
      if (low_clear) kind = KIND_INDEX;
    end else begin
      // summary space: one register per group, upper field must be zero
      grp = addr[REG_SHIFT +: GRP_W];
      if (low_clear && addr[ADDR_W-2 -: IDX_W] == '0) kind = KIND_SUMMARY;
    end
  end
endmodule

// File: rtl/msi_group_bank.sv
module msi_group_bank #(
  parameter int NUM_IDX = 8,
  parameter int VEC_W   = 16,
  localparam int IDX_W  = $clog2(NUM_IDX)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_en,
  input  logic [IDX_W-1:0]         set_idx,
  input  logic [VEC_W-1:0]         set_mask,
  input  logic                     clr_en,
  input  logic [IDX_W-1:0]         clr_idx,
  output logic [NUM_IDX*VEC_W-1:0] pend_flat,
  output logic [NUM_IDX-1:0]       summary,
  output logic                     irq
);
  for (genvar i = 0; i < NUM_IDX; i++) begin : g_idx
    logic [VEC_W-1:0] bits_q;
    logic             hit_set;
    logic             hit_clr;

    assign hit_set = set_en && (set_idx == IDX_W'(i));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits_q <= '0;
      end else if (hit_set || hit_clr) begin
        // clearing read first, then the new bit on top so it survives
        bits_q <= (hit_clr ? '0 : bits_q) | (hit_set ? set_mask : '0);
      end
    end

    assign pend_flat[i*VEC_W +: VEC_W] = bits_q;
    assign summary[i]                  = |bits_q;
  end

  assign irq = |summary;
endmodule

// File: rtl/msi_term_agg.sv
module msi_term_agg
  import msi_term_pkg::*;
#(
  parameter int NUM_GRP   = 16,
  parameter int NUM_IDX   = 8,
  parameter int VEC_W     = 16,
  parameter int DATA_W    = 32,
  parameter int REG_SHIFT = 16,
  localparam int GRP_W    = $clog2(NUM_GRP),
  localparam int IDX_W    = $clog2(NUM_IDX),
  localparam int BIT_W    = $clog2(VEC_W),
  localparam int ADDR_W   = REG_SHIFT + IDX_W + GRP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [VEC_W-1:0]  rd_data,
  output logic [NUM_GRP-1:0] irq
);
  // write side decode
  reg_kind_e        wr_kind;
  logic [GRP_W-1:0] wr_grp;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_data_ok;
  logic             wr_hit;
  logic [VEC_W-1:0] wr_mask;

  msi_addr_decode #(.GRP_W(GRP_W), .IDX_W(IDX_W), .REG_SHIFT(REG_SHIFT)) u_wr_dec (
    .addr (wr_addr),
    .kind (wr_kind),
    .grp  (wr_grp),
    .idx  (wr_idx)
  );

  assign wr_data_ok = (wr_data[DATA_W-1:BIT_W] == '0);
  assign wr_hit     = wr_valid && wr_data_ok && (wr_kind == KIND_INDEX);
  assign wr_mask    = VEC_W'(1) << wr_data[BIT_W-1:0];

  // read side decode
  reg_kind_e        rd_kind;
  logic [GRP_W-1:0] rd_grp;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_clr;

  msi_addr_decode #(.GRP_W(GRP_W), .IDX_W(IDX_W), .REG_SHIFT(REG_SHIFT)) u_rd_dec (
    .addr (rd_addr),
    .kind (rd_kind),
    .grp  (rd_grp),
    .idx  (rd_idx)
  );

  assign rd_clr = rd_en && (rd_kind == KIND_INDEX);

  // pending storage, one bank per group
  logic [NUM_IDX*VEC_W-1:0] grp_pend [NUM_GRP];
  logic [NUM_IDX-1:0]       grp_sum  [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    msi_group_bank #(.NUM_IDX(NUM_IDX), .VEC_W(VEC_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (wr_hit && (wr_grp == GRP_W'(g))),
      .set_idx   (wr_idx),
      .set_mask  (wr_mask),
      .clr_en    (rd_clr && (rd_grp == GRP_W'(g))),
      .clr_idx   (rd_idx),
      .pend_flat (grp_pend[g]),
      .summary   (grp_sum[g]),
      .irq       (irq[g])
    );
  end

  // read mux, registered
  logic [VEC_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (rd_en) begin
      unique case (rd_kind)
        KIND_INDEX:   rd_next = grp_pend[rd_grp][rd_idx*VEC_W +: VEC_W];
        KIND_SUMMARY: rd_next = VEC_W'(grp_sum[rd_grp]);
        default:      rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end
endmodule

// File: rtl/msi_term_agg_chk.sv
module msi_term_agg_chk #(
  parameter int NUM_GRP   = 16,
  parameter int NUM_IDX   = 8,
  parameter int VEC_W     = 16,
  parameter int DATA_W    = 32,
  parameter int REG_SHIFT = 16,
  localparam int GRP_W    = $clog2(NUM_GRP),
  localparam int IDX_W    = $clog2(NUM_IDX),
  localparam int ADDR_W   = REG_SHIFT + IDX_W + GRP_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [VEC_W-1:0]   rd_data,
  input logic [NUM_GRP-1:0] irq
);
  logic good_wr;
  logic bad_wr;
  assign good_wr = wr_valid && (wr_data < DATA_W'(VEC_W)) && !wr_addr[ADDR_W-1]
                   && (wr_addr[REG_SHIFT-1:0] == '0);
  assign bad_wr  = wr_valid && ((wr_data >= DATA_W'(VEC_W)) || wr_addr[ADDR_W-1]
                   || (wr_addr[REG_SHIFT-1:0] != '0));

  // R7: reset holds every line low
  a_r7_reset_low: assert property (@(posedge clk) !rst_n |=> irq == '0);

  // R3: an accepted write raises its group line on the next cycle
  a_r3_write_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr |=> irq[$past(wr_addr[ADDR_W-2 -: GRP_W])]);

  // R3: no line rises without a write in the cycle before
  a_r3_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(irq)) != '0) |-> $past(wr_valid));

  // R6: a dropped write leaves all lines unchanged when no read clears
  a_r6_drop_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_wr && !rd_en) |=> $stable(irq));

  // R9: no read, zero read data next cycle
  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);

  logic unused_ok;
  assign unused_ok = ^rd_addr;
endmodule

bind msi_term_agg msi_term_agg_chk u_chk (.*);

// File: tb/msi_term_agg_tb_top.sv
module msi_term_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [23:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [15:0] irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  msi_term_agg dut_i (.*);

  function automatic logic [23:0] idx_addr(int g, int x);
    return 24'((g << 19) | (x << 16));
  endfunction
  function automatic logic [23:0] sum_addr(int g);
    return 24'(32'h80_0000 | (g << 16));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [23:0] a, logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(logic [23:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R7 irq after reset", 32'(irq), 0);
    do_read(sum_addr(0), v);  check("R7 summary g0 clear", 32'(v), 0);
    do_read(idx_addr(15, 7), v); check("R7 index g15 x7 clear", 32'(v), 0);
  endtask

  task automatic t_vector(int vec);
    logic [15:0] v;
    int g = vec % 16;
    int x = vec / 256;
    int d = (vec / 16) % 16;
    do_write(idx_addr(g, x), 32'(d));
    check($sformatf("R3 irq for vector %0d", vec), 32'(irq), 32'(1 << g));
    do_read(sum_addr(g), v);
    check("R2 summary of vector group", 32'(v), 32'(1 << x));
    do_read(idx_addr(g, x), v);
    check($sformatf("R1 R8 bit of vector %0d", vec), 32'(v), 32'(1 << d));
    check("R4 irq falls after drain", 32'(irq), 0);
    do_read(idx_addr(g, x), v);
    check("R4 register cleared", 32'(v), 0);
  endtask

  task automatic t_summary();
    logic [15:0] v;
    do_write(idx_addr(5, 2), 3);
    do_write(idx_addr(5, 7), 0);
    do_read(sum_addr(5), v);  check("R2 summary two indexes", 32'(v), 32'h84);
    do_read(sum_addr(5), v);  check("R9 summary read no side effect", 32'(v), 32'h84);
    do_read(idx_addr(5, 2), v); check("R4 read index 2", 32'(v), 32'h8);
    do_read(sum_addr(5), v);  check("R4 summary after partial drain", 32'(v), 32'h80);
    check("R3 irq held while pending", 32'(irq), 32'h20);
    do_read(idx_addr(5, 7), v); check("R4 read index 7", 32'(v), 32'h1);
    check("R4 irq falls when group empty", 32'(irq), 0);
  endtask

  task automatic t_coalesce();
    logic [15:0] v;
    do_write(idx_addr(9, 4), 6);
    do_write(idx_addr(9, 4), 6);
    do_write(idx_addr(9, 4), 15);
    do_read(idx_addr(9, 4), v);
    check("R10 sticky coalesced bits", 32'(v), 32'h8040);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    do_write(idx_addr(3, 1), 4);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = idx_addr(3, 1);
    wr_valid = 1'b1; wr_addr = idx_addr(3, 1); wr_data = 9;
    @(negedge clk);
    rd_en = 1'b0; wr_valid = 1'b0;
    check("R5 read returns old content", 32'(rd_data), 32'h10);
    check("R5 irq stays for new bit", 32'(irq), 32'h8);
    do_read(idx_addr(3, 1), v);
    check("R5 written bit not lost", 32'(v), 32'h200);
  endtask

  task automatic t_dropped();
    logic [15:0] v;
    do_write(idx_addr(2, 0), 16);
    do_write(24'h80_0000, 1);
    do_write(24'h00_0004, 1);
    check("R6 no irq from dropped writes", 32'(irq), 0);
    do_read(idx_addr(2, 0), v);  check("R6 big data dropped", 32'(v), 0);
    do_read(idx_addr(0, 0), v);  check("R6 misaligned dropped", 32'(v), 0);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    do_write(idx_addr(1, 0), 1);
    do_read(24'h90_0000, v);  check("R9 unmapped read zero", 32'(v), 0);
    do_read(24'h00_0008, v);  check("R9 off-stride read zero", 32'(v), 0);
    @(negedge clk);
    check("R9 idle rd_data zero", 32'(rd_data), 0);
    check("R9 unmapped read kept pending", 32'(irq), 32'h2);
    do_read(idx_addr(1, 0), v);  check("R9 pending intact", 32'(v), 32'h2);
  endtask

  task automatic t_groups();
    logic [15:0] v;
    do_write(idx_addr(0, 0), 0);
    do_write(idx_addr(15, 7), 15);
    check("R3 independent group lines", 32'(irq), 32'h8001);
    do_read(idx_addr(0, 0), v);
    check("R3 other group untouched", 32'(irq), 32'h8000);
    do_read(idx_addr(15, 7), v);
    check("R8 top vector bit", 32'(v), 32'h8000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_vector(0);
    t_vector(37);
    t_vector(1000);
    t_vector(2047);
    t_summary();
    t_coalesce();
    t_collision();
    t_dropped();
    t_unmapped();
    t_groups();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule